// File: doc/BRIEF.md
# XOR-Banked Multi-Write Register File

This block is a register-file memory that takes several independent writes and serves several independent reads in every clock cycle. It does not time-multiplex the storage. Each write port has a private storage bank, and only that port ever writes it. A logical word is never held in one place. It is the exclusive-OR of the entries at that address across all banks.

When a port writes, it stores its data XORed with what the other banks hold at the same address. The XOR across all banks then equals the new data. A read port XORs the entries at its address across all banks, combinationally.

The default configuration has 256 words of 32 bits, three write ports and four read ports. All of these are parameters. When two enabled writers name the same address in one cycle, a clash flag goes high. Only the lowest-numbered of those writers is committed.

Top module: `xor_bank_regfile`

## Requirements
- R1: Three enabled write ports with pairwise distinct addresses all commit at the same rising edge. Each address then reads back its own port's data from the following cycle on.
- R2: Each of the four read ports combinationally returns the current word at its own address, independently of the other read ports, including when several ports read the same address.
- R3: A write through any port replaces the stored word, whichever ports wrote that address before. For example, write 0xa through port 0, then 0x6 through port 1, then 0x0 through port 2, then 0x7 through port 1. The address then reads 0x7.
- R4: A read of an address that is being written in the same cycle returns the value from before the write. The new value appears from the next cycle on.
- R5: `wrClash` is high in a cycle exactly when two or more enabled write ports present the same address. Ports whose enable is low are ignored in this comparison.
- R6: During a clash, only the lowest-numbered enabled port among those sharing the address commits. The other writes to that address are dropped. Ports writing other addresses in that cycle still commit.
- R7: After a rising edge with `rst` high, every address reads as zero. A write presented while `rst` is high has no effect.
- R8: A write port whose enable bit is low changes no stored word, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all storage updates on the rising edge |
| rst | input | 1 | Synchronous reset; clears every bank |
| wrEn | input | NWR (3) | Write enable per write port, bit p for port p |
| wrAddr | input | NWR*AW (24) | Write addresses; port p uses bits [p*AW +: AW] |
| wrData | input | NWR*W (96) | Write data; port p uses bits [p*W +: W] |
| rdAddr | input | NRD*AW (32) | Read addresses; port r uses bits [r*AW +: AW] |
| rdData | output | NRD*W (128) | Read data, combinational; port r on bits [r*W +: W] |
| wrClash | output | 1 | High when two or more enabled writers share an address |

## Verification
The assertions check the following on every cycle:
- The committed write mask is a subset of the enables.
- Port 0 always wins when enabled.
- No two committed ports share an address.
- Absence of a clash passes every enable through.
- Every read port returns zero after a reset edge.
- Read data holds still when nothing was committed and the read addresses are unchanged.

Only the bench's scenarios can show that the XOR encoding returns the written value. This covers cross-port overwrites of the same address, the pre-write value on a same-cycle read, and which writer survives a clash. These are compared against a single flat reference array.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

  localparam int unsigned XBR_DEPTH_DEF = 256;
  localparam int unsigned XBR_WIDTH_DEF = 32;
  localparam int unsigned XBR_NWR_DEF   = 3;
  localparam int unsigned XBR_NRD_DEF   = 4;

  // Strobes from control to datapath, sized for the default port count.
  typedef struct packed {
    logic [XBR_NWR_DEF-1:0] commit;
    logic                   clash;
  } xbrStrobe_t;

endpackage

// File: rtl/xbr_bank.sv
module xbr_bank #(
  parameter int unsigned W   = 32,
  parameter int unsigned D   = 256,
  parameter int unsigned AW  = 8,
  parameter int unsigned NWR = 3,
  parameter int unsigned NRD = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [AW-1:0]            wAddr,
  input  logic [W-1:0]             wWord,
  input  logic [NWR-1:0][AW-1:0]   peekAddrW,
  input  logic [NRD-1:0][AW-1:0]   peekAddrR,
  output logic [NWR-1:0][W-1:0]    peekW,
  output logic [NRD-1:0][W-1:0]    peekR
);

  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(D); i++) mem[i] <= '0;
    end else if (we) begin
      mem[wAddr] <= wWord;
    end
  end

  // Asynchronous lookups: one per write port (encoding), one per read port.
  always_comb begin
    for (int q = 0; q < int'(NWR); q++) peekW[q] = mem[peekAddrW[q]];
    for (int r = 0; r < int'(NRD); r++) peekR[r] = mem[peekAddrR[r]];
  end

endmodule

// File: rtl/xbr_control.sv
module xbr_control #(
  parameter int unsigned NWR = 3,
  parameter int unsigned AW  = 8,
  parameter type strobe_t    = xbr_pkg::xbrStrobe_t
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NWR-1:0]         wrEn,
  input  logic [NWR-1:0][AW-1:0] wAddr,
  output strobe_t                ctl
);

  logic beaten;

  always_comb begin
    ctl    = '0;
    beaten = 1'b0;
    for (int p = 0; p < int'(NWR); p++) begin
      beaten = 1'b0;
      for (int q = 0; q < int'(NWR); q++) begin
        if (q < p && wrEn[q] && wAddr[q] == wAddr[p]) beaten = 1'b1;
      end
      ctl.commit[p] = wrEn[p] & ~beaten;
      if (wrEn[p] && beaten) ctl.clash = 1'b1;
    end
  end

  // R8: nothing commits without its enable
  p_subset_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl.commit & ~wrEn) == '0);

  // R6: port 0 is never overruled
  p_lowest_r6: assert property (@(posedge clk) disable iff (rst)
    wrEn[0] |-> ctl.commit[0]);

  // R6: a clash drops at least one enabled writer
  p_fewer_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.clash |-> ($countones(ctl.commit) < $countones(wrEn)));

  // R5: without a clash every enabled writer commits
  p_pass_r5: assert property (@(posedge clk) disable iff (rst)
    !ctl.clash |-> (ctl.commit == wrEn));

endmodule

// File: rtl/xbr_datapath.sv
module xbr_datapath #(
  parameter int unsigned W   = 32,
  parameter int unsigned D   = 256,
  parameter int unsigned AW  = 8,
  parameter int unsigned NWR = 3,
  parameter int unsigned NRD = 4,
  parameter type strobe_t    = xbr_pkg::xbrStrobe_t
) (
  input  logic                   clk,
  input  logic                   rst,
  input  strobe_t                ctl,
  input  logic [NWR-1:0][AW-1:0] wAddr,
  input  logic [NWR-1:0][W-1:0]  wData,
  input  logic [NRD-1:0][AW-1:0] rAddr,
  output logic [NRD-1:0][W-1:0]  rdWord
);

  logic [NWR-1:0][NWR-1:0][W-1:0] wPeek;   // [bank][write port]
  logic [NWR-1:0][NRD-1:0][W-1:0] rPeek;   // [bank][read port]
  logic [NWR-1:0][W-1:0]          encWord;

  for (genvar b = 0; b < int'(NWR); b++) begin : g_bank
    xbr_bank #(.W(W), .D(D), .AW(AW), .NWR(NWR), .NRD(NRD)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .we        (ctl.commit[b]),
      .wAddr     (wAddr[b]),
      .wWord     (encWord[b]),
      .peekAddrW (wAddr),
      .peekAddrR (rAddr),
      .peekW     (wPeek[b]),
      .peekR     (rPeek[b])
    );
  end

  // Write encoding: data XOR every other bank at the same address.
  always_comb begin
    for (int p = 0; p < int'(NWR); p++) begin
      encWord[p] = wData[p];
      for (int b = 0; b < int'(NWR); b++) begin
        if (b != p) encWord[p] = encWord[p] ^ wPeek[b][p];
      end
    end
  end

  // Read decoding: XOR of all banks at the read address.
  always_comb begin
    for (int r = 0; r < int'(NRD); r++) begin
      rdWord[r] = '0;
      for (int b = 0; b < int'(NWR); b++) rdWord[r] = rdWord[r] ^ rPeek[b][r];
    end
  end

  // R5: two committed writers never share an address
  for (genvar p = 0; p < int'(NWR); p++) begin : g_pair_p
    for (genvar q = p + 1; q < int'(NWR); q++) begin : g_pair_q
      p_distinct_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.commit[p] && ctl.commit[q]) |-> (wAddr[p] != wAddr[q]));
    end
  end

  // R6: a clash still lets one writer through
  p_keep_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.clash |-> (ctl.commit != '0));

  // R7: everything reads zero after a reset edge
  p_clear_r7: assert property (@(posedge clk)
    rst |=> (rdWord == '0));

  // R8: no commit and unchanged addresses leave read data unchanged
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl.commit == '0) ##1 $stable(rAddr) |-> $stable(rdWord));

endmodule

// File: rtl/xor_bank_regfile.sv
module xor_bank_regfile #(
  parameter int unsigned W   = xbr_pkg::XBR_WIDTH_DEF,
  parameter int unsigned D   = xbr_pkg::XBR_DEPTH_DEF,
  parameter int unsigned NWR = xbr_pkg::XBR_NWR_DEF,
  parameter int unsigned NRD = xbr_pkg::XBR_NRD_DEF,
  localparam int unsigned AW = (D > 1) ? $clog2(D) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NWR-1:0]   wrEn,
  input  logic [NWR*AW-1:0] wrAddr,
  input  logic [NWR*W-1:0] wrData,
  input  logic [NRD*AW-1:0] rdAddr,
  output logic [NRD*W-1:0] rdData,
  output logic             wrClash
);

  typedef struct packed {
    logic [NWR-1:0] commit;
    logic           clash;
  } strobe_t;

  strobe_t                ctl;
  logic [NWR-1:0][AW-1:0] wAddr;
  logic [NWR-1:0][W-1:0]  wData;
  logic [NRD-1:0][AW-1:0] rAddr;
  logic [NRD-1:0][W-1:0]  rdWord;

  assign wAddr   = wrAddr;
  assign wData   = wrData;
  assign rAddr   = rdAddr;
  assign rdData  = rdWord;
  assign wrClash = ctl.clash;

  xbr_control #(.NWR(NWR), .AW(AW), .strobe_t(strobe_t)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wrEn  (wrEn),
    .wAddr (wAddr),
    .ctl   (ctl)
  );

  xbr_datapath #(.W(W), .D(D), .AW(AW), .NWR(NWR), .NRD(NRD),
                 .strobe_t(strobe_t)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .wAddr  (wAddr),
    .wData  (wData),
    .rAddr  (rAddr),
    .rdWord (rdWord)
  );

endmodule

// File: tb/sim_xor_bank_regfile.sv
module sim_xor_bank_regfile;

  localparam int W   = 32;
  localparam int D   = 256;
  localparam int NWR = 3;
  localparam int NRD = 4;
  localparam int AW  = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic [NWR-1:0]    wrEn;
  logic [NWR*AW-1:0] wrAddr;
  logic [NWR*W-1:0]  wrData;
  logic [NRD*AW-1:0] rdAddr;
  logic [NRD*W-1:0]  rdData;
  logic              wrClash;

  logic [AW-1:0] bWA [NWR];
  logic [W-1:0]  bWD [NWR];
  logic [AW-1:0] bRA [NRD];
  logic [W-1:0]  refMem [D];

  int  errCount = 0;
  int  chkCount = 0;
  bit  finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  for (genvar p = 0; p < NWR; p++) begin : g_wp
    assign wrAddr[p*AW +: AW] = bWA[p];
    assign wrData[p*W +: W]   = bWD[p];
  end
  for (genvar r = 0; r < NRD; r++) begin : g_rp
    assign rdAddr[r*AW +: AW] = bRA[r];
  end

  xor_bank_regfile u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .wrClash(wrClash)
  );

  function automatic bit expClash();
    for (int p = 0; p < NWR; p++)
      for (int q = p + 1; q < NWR; q++)
        if (wrEn[p] && wrEn[q] && bWA[p] == bWA[q]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit wins(int p);
    if (!wrEn[p]) return 1'b0;
    for (int q = 0; q < p; q++)
      if (wrEn[q] && bWA[q] == bWA[p]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idleInputs();
    wrEn = '0;
    for (int p = 0; p < NWR; p++) begin bWA[p] = '0; bWD[p] = '0; end
    for (int r = 0; r < NRD; r++) bRA[r] = '0;
  endtask

  // Inputs are set after a negedge; sample before the posedge, then update the model.
  task automatic stepCheck(string req);
    #1;
    if (!rst) begin
      for (int r = 0; r < NRD; r++)
        check(req, rdData[r*W +: W], refMem[bRA[r]]);
      check({req, " clash"}, {31'd0, wrClash}, {31'd0, expClash()});
    end
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < D; i++) refMem[i] = '0;
    end else begin
      for (int p = 0; p < NWR; p++) if (wins(p)) refMem[bWA[p]] = bWD[p];
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1337));
    for (int i = 0; i < D; i++) refMem[i] = 'x;
    rst = 1'b1;
    idleInputs();
    // R7: writes presented during reset are ignored
    wrEn = 3'b111; bWA[0] = 8'd5; bWA[1] = 8'd6; bWA[2] = 8'd7;
    bWD[0] = 32'h1111_1111; bWD[1] = 32'h2222_2222; bWD[2] = 32'h3333_3333;
    stepCheck("R7");
    stepCheck("R7");
    rst = 1'b0;
    idleInputs();
    bRA[0] = 8'd5; bRA[1] = 8'd6; bRA[2] = 8'd7; bRA[3] = 8'd255;
    for (int r = 0; r < NRD; r++) check("R7 reset read", rdData[r*W +: W], 32'h0);
    stepCheck("R7");

    // R1: three distinct writes in one cycle
    wrEn = 3'b111; bWA[0] = 8'd20; bWA[1] = 8'd21; bWA[2] = 8'd22;
    bWD[0] = 32'hA0A0_0001; bWD[1] = 32'hB1B1_0002; bWD[2] = 32'hC2C2_0003;
    bRA[0] = 8'd20; bRA[1] = 8'd21; bRA[2] = 8'd22; bRA[3] = 8'd20;
    stepCheck("R1/R4 pre-write");
    wrEn = '0;
    check("R1", rdData[0 +: W], 32'hA0A0_0001);
    check("R1", rdData[W +: W], 32'hB1B1_0002);
    check("R2 shared addr", rdData[3*W +: W], 32'hA0A0_0001);
    stepCheck("R1/R2");

    // R3: cross-port overwrites of one address, in the manner of the worked example
    bRA[0] = 8'd12; bRA[1] = 8'd12; bRA[2] = 8'd13; bRA[3] = 8'd12;
    wrEn = 3'b001; bWA[0] = 8'd12; bWD[0] = 32'ha; stepCheck("R3");
    wrEn = 3'b010; bWA[1] = 8'd12; bWD[1] = 32'h6; stepCheck("R3");
    wrEn = 3'b100; bWA[2] = 8'd12; bWD[2] = 32'h0; stepCheck("R3");
    wrEn = 3'b010; bWA[1] = 8'd12; bWD[1] = 32'h7;
    #1; check("R4 old value", rdData[0 +: W], 32'h0);
    stepCheck("R3/R4");
    wrEn = '0;
    #1; check("R3 read after cross-port write", rdData[0 +: W], 32'h7);
    stepCheck("R3");

    // R5/R6: ports 0 and 2 clash, port 1 distinct
    wrEn = 3'b111; bWA[0] = 8'd40; bWA[1] = 8'd41; bWA[2] = 8'd40;
    bWD[0] = 32'hDEAD_0000; bWD[1] = 32'hBEEF_0001; bWD[2] = 32'hFEED_0002;
    bRA[0] = 8'd40; bRA[1] = 8'd41;
    #1; check("R5 clash high", {31'd0, wrClash}, 32'd1);
    stepCheck("R5/R6");
    wrEn = '0;
    #1; check("R6 lowest kept", rdData[0 +: W], 32'hDEAD_0000);
    check("R6 other port kept", rdData[W +: W], 32'hBEEF_0001);
    stepCheck("R6");
    // R6: ports 1 and 2 clash, port 0 disabled at same address (R5 ignores it)
    wrEn = 3'b110; bWA[0] = 8'd40; bWA[1] = 8'd40; bWA[2] = 8'd40;
    bWD[0] = 32'h0BAD_0BAD; bWD[1] = 32'h1234_5678; bWD[2] = 32'h8765_4321;
    stepCheck("R5/R6");
    wrEn = '0;
    #1; check("R6 port1 wins", rdData[0 +: W], 32'h1234_5678);
    stepCheck("R6");
    // R5/R8: disabled port sharing an address is no clash and writes nothing
    wrEn = 3'b010; bWA[0] = 8'd41; bWA[1] = 8'd41; bWD[0] = 32'h5555_5555; bWD[1] = 32'h0000_0041;
    #1; check("R5 disabled ignored", {31'd0, wrClash}, 32'd0);
    stepCheck("R5/R8");
    wrEn = 3'b000; bWA[2] = 8'd40; bWD[2] = 32'hFFFF_FFFF;
    stepCheck("R8");
    #1; check("R8 no effect", rdData[0 +: W], 32'h1234_5678);
    stepCheck("R8");

    // Random concurrent, non-colliding traffic (R1, R2, R4)
    for (int i = 0; i < D; i++) begin
      wrEn = 3'b111;
      bWA[0] = i[AW-1:0]; bWA[1] = ~i[AW-1:0]; bWA[2] = i[AW-1:0] ^ 8'h55;
      bWD[0] = $urandom; bWD[1] = $urandom; bWD[2] = $urandom;
      if (bWA[2] == bWA[0] || bWA[2] == bWA[1]) wrEn[2] = 1'b0;
      stepCheck("R1 fill");
    end
    for (int n = 0; n < 600; n++) begin
      wrEn = 3'($urandom);
      for (int p = 0; p < NWR; p++) begin
        bWA[p] = AW'($urandom_range(0, ($urandom_range(0, 1) == 0) ? 15 : D - 1));
        bWD[p] = $urandom;
      end
      for (int p = 1; p < NWR; p++)
        for (int q = 0; q < p; q++)
          if (bWA[p] == bWA[q]) bWA[p] = bWA[q] + AW'(p);
      for (int p = 1; p < NWR; p++)
        for (int q = 0; q < p; q++)
          if (bWA[p] == bWA[q]) wrEn[p] = 1'b0;
      for (int r = 0; r < NRD; r++)
        bRA[r] = ($urandom_range(0, 2) == 0) ? bWA[$urandom_range(0, NWR - 1)]
                                              : AW'($urandom_range(0, 15));
      stepCheck("R2/R4 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

endmodule